// File: doc/BRIEF.md
# Elided Lock Buffer

This block lets a core run a lock-protected critical section speculatively, without writing to the lock line. An acquire-tagged store to a lock address does not go to the cache. The block opens a transaction with the transactional tracker and keeps the lock address and the stored word in a small private buffer. Local loads that hit a buffered lock address read the buffered word. A release-tagged store to the same address closes one nesting level. When the last level closes, the buffered lock words are handed to memory, one at a time.

Acquire and release stores arrive on one valid/ready stream. An op is consumed on a cycle where `op_valid` and `op_ready` are both high. `op_ready` is low in three cases: while the lock line is not held Shared or Exclusive with its transactional mark set (`line_held` low), while a conflict is flagged, and while the buffer is draining. A producer must hold its op stable until the op is accepted.

The drain to memory is a second valid/ready stream. An entry is retired only when `cm_valid` and `cm_ready` are both high. While the consumer stalls, the entry stays on the bus unchanged. A conflict, an overflow or an unmatched release aborts the section. An abort empties the buffer and sends nothing to memory.

Top module: `elided_lock_buffer`

## Requirements
- R1: After reset no entry is valid (`ld_hit` is 0 for any address), `tx_begin`, `tx_commit`, `tx_abort` and `cm_valid` are 0, and `op_ready` is 1 while `line_held` is 1.
- R2: An accepted acquire (`op_kind`=0) to an address with no valid entry fills the lowest free entry with that address and word. It pulses `tx_begin` for one cycle, in the cycle after acceptance.
- R3: `ld_hit` and `ld_data` respond in the same cycle. `ld_hit` is 1 and `ld_data` equals the buffered word when `ld_addr` matches a valid entry; otherwise `ld_hit` is 0.
- R4: An acquire to an address already buffered overwrites that entry's word in place, allocates no new entry, pulses `tx_begin` and raises the nesting depth by one.
- R5: An acquire to a new address while all entries are valid pulses `tx_abort` and invalidates every entry.
- R6: An accepted release (`op_kind`=1) that matches a valid entry stores its word in that entry and pulses `tx_commit`. When the depth before the release was above 1, the entries stay valid and nothing is drained.
- R7: A matching release that brings the depth to 0 starts a drain. Valid entries go out on `cm_addr`/`cm_data` in ascending entry order, and each is held until `cm_ready`. `cm_last` marks the final entry, and `op_ready` stays 0 until the drain ends.
- R8: A release that matches no valid entry pulses `tx_abort`, invalidates every entry and drains nothing.
- R9: `conflict` high while the depth is above 0 and no drain runs pulses `tx_abort` in the next cycle, with every entry invalid and `cm_valid` 0.
- R10: `conflict` has no effect when the depth is 0 or while a drain runs. No command is issued, and the drain continues unchanged.
- R11: An acquire accepted while the depth equals `DEPTH_MAX` pulses `tx_abort` and invalidates every entry.
- R12: While `line_held` is 0, `op_ready` is 0, the op is not consumed and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_held | input | 1 | Lock line held Shared/Exclusive with transactional mark |
| op_valid | input | 1 | Tagged store offered |
| op_ready | output | 1 | Tagged store accepted this cycle |
| op_kind | input | 1 | 0 acquire, 1 release |
| op_addr | input | ADDR_W | Lock address of the tagged store |
| op_data | input | DATA_W | Word written by the tagged store |
| ld_addr | input | ADDR_W | Local load address |
| ld_hit | output | 1 | Load matches a buffered lock |
| ld_data | output | DATA_W | Buffered word for the load |
| conflict | input | 1 | Conflict on a marked line reported by the cache |
| tx_begin | output | 1 | Begin command to the tracker |
| tx_commit | output | 1 | Commit (nesting decrement) command to the tracker |
| tx_abort | output | 1 | Abort command to the tracker |
| cm_valid | output | 1 | Buffered lock word offered to memory |
| cm_ready | input | 1 | Memory takes the offered word |
| cm_addr | output | ADDR_W | Address of the offered word |
| cm_data | output | DATA_W | Offered word |
| cm_last | output | 1 | Offered word is the last of the drain |

## Verification
The assertions assume the two stream rules hold. A producer keeps `op_kind`, `op_addr` and `op_data` steady until the op is accepted, and `cm_ready` is only a consumer's choice. Nothing downstream needs `cm_valid` to drop in response. The stimulus changes op fields only at falling edges and drops `op_valid` right after each acceptance. It raises `conflict` for one cycle at a time, and it keeps `cm_ready` low for several cycles before letting the drain move. The bench lowers the depth limit so that overflow is reachable in a few ops.

// File: rtl/elb_pkg.sv
package elb_pkg;
  typedef enum logic { OP_ACQ = 1'b0, OP_REL = 1'b1 } op_kind_e;
  typedef enum logic [1:0] { CMD_NONE, CMD_BEGIN, CMD_COMMIT, CMD_ABORT } cmd_e;
  typedef enum logic { ST_OPEN, ST_DRAIN } state_e;
endpackage

// File: rtl/elb_pick.sv
// Lowest-index set bit finder.
module elb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/elb_store.sv
// Entry array: match, allocate, forward, drain pointer.
module elb_store #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IW      = 2,
  parameter int CW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              do_upd,
  input  logic              do_alloc,
  input  logic              do_pop,
  input  logic              do_clear,
  output logic              op_hit,
  output logic              free_any,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic              cm_last,
  output logic [CW-1:0]     valid_cnt
);
  logic [ENTRIES-1:0] vld;
  logic [ADDR_W-1:0]  adr [ENTRIES];
  logic [DATA_W-1:0]  dat [ENTRIES];
  logic [ENTRIES-1:0] op_match;
  logic [ENTRIES-1:0] ld_match;
  logic [IW-1:0]      hit_idx, free_idx, drn_idx;
  logic               drn_any;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign op_match[g] = vld[g] && (adr[g] == op_addr);
    assign ld_match[g] = vld[g] && (adr[g] == ld_addr);
  end

  elb_pick #(.N(ENTRIES), .IW(IW)) u_hit  (.req(op_match), .found(op_hit),   .idx(hit_idx));
  elb_pick #(.N(ENTRIES), .IW(IW)) u_free (.req(~vld),     .found(free_any), .idx(free_idx));
  elb_pick #(.N(ENTRIES), .IW(IW)) u_drn  (.req(vld),      .found(drn_any),  .idx(drn_idx));

  always_comb begin
    ld_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ld_match[i]) ld_data = ld_data | dat[i];
    end
  end
  assign ld_hit = |ld_match;

  always_comb begin
    valid_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) valid_cnt = valid_cnt + CW'(vld[i]);
  end

  assign cm_addr = adr[drn_idx];
  assign cm_data = dat[drn_idx];
  assign cm_last = drn_any && (valid_cnt == CW'(1));

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n || do_clear) begin
        vld[i] <= 1'b0;
      end else if (do_alloc && free_idx == IW'(i)) begin
        vld[i] <= 1'b1;
      end else if (do_pop && drn_idx == IW'(i)) begin
        vld[i] <= 1'b0;
      end
      if (do_alloc && free_idx == IW'(i)) adr[i] <= op_addr;
      if ((do_alloc && free_idx == IW'(i)) || (do_upd && hit_idx == IW'(i)))
        dat[i] <= op_data;
    end
  end

  // R4: a lock address never occupies two entries.
  assert_unique_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_match));
endmodule

// File: rtl/elb_seq.sv
// Nesting depth, command issue and drain sequencing.
module elb_seq
  import elb_pkg::*;
#(
  parameter int DEPTH_MAX = 15,
  parameter int CNT_W     = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     op_valid,
  input  op_kind_e op_kind,
  input  logic     line_held,
  input  logic     conflict,
  input  logic     cm_ready,
  input  logic     cm_last,
  input  logic     op_hit,
  input  logic     free_any,
  output logic     op_ready,
  output logic     do_upd,
  output logic     do_alloc,
  output logic     do_pop,
  output logic     do_clear,
  output logic     tx_begin,
  output logic     tx_commit,
  output logic     tx_abort,
  output logic     cm_valid
);
  state_e          st_q, st_d;
  cmd_e            cmd_q, cmd_d;
  logic [CNT_W-1:0] depth_q, depth_d;
  logic            accept, at_max, nested;

  assign op_ready = (st_q == ST_OPEN) && !conflict && line_held;
  assign accept   = op_valid && op_ready;
  assign at_max   = depth_q == CNT_W'(DEPTH_MAX);
  assign nested   = depth_q != '0;

  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NONE;
    depth_d  = depth_q;
    do_upd   = 1'b0;
    do_alloc = 1'b0;
    do_pop   = 1'b0;
    do_clear = 1'b0;
    if (st_q == ST_DRAIN) begin
      do_pop = cm_ready;
      if (cm_ready && cm_last) st_d = ST_OPEN;
    end else if (conflict && nested) begin
      do_clear = 1'b1;
      cmd_d    = CMD_ABORT;
      depth_d  = '0;
    end else if (accept) begin
      if (op_kind == OP_ACQ) begin
        if (at_max || (!op_hit && !free_any)) begin
          do_clear = 1'b1;
          cmd_d    = CMD_ABORT;
          depth_d  = '0;
        end else begin
          do_upd   = op_hit;
          do_alloc = !op_hit;
          cmd_d    = CMD_BEGIN;
          depth_d  = depth_q + CNT_W'(1);
        end
      end else begin
        if (op_hit && nested) begin
          do_upd  = 1'b1;
          cmd_d   = CMD_COMMIT;
          depth_d = depth_q - CNT_W'(1);
          if (depth_q == CNT_W'(1)) st_d = ST_DRAIN;
        end else begin
          do_clear = 1'b1;
          cmd_d    = CMD_ABORT;
          depth_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_OPEN;
      cmd_q   <= CMD_NONE;
      depth_q <= '0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      depth_q <= depth_d;
    end
  end

  assign tx_begin  = cmd_q == CMD_BEGIN;
  assign tx_commit = cmd_q == CMD_COMMIT;
  assign tx_abort  = cmd_q == CMD_ABORT;
  assign cm_valid  = st_q == ST_DRAIN;

  // R11: depth never passes its ceiling.
  assert_depth_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CNT_W'(DEPTH_MAX));
  // R7: a drain only opens after a commit.
  assert_drain_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cm_valid) |-> tx_commit);
endmodule

// File: rtl/elided_lock_buffer.sv
module elided_lock_buffer
  import elb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ENTRIES   = 4,
  parameter int DEPTH_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_held,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  input  logic              conflict,
  output logic              tx_begin,
  output logic              tx_commit,
  output logic              tx_abort,
  output logic              cm_valid,
  input  logic              cm_ready,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic              cm_last
);
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW    = $clog2(ENTRIES + 1);
  localparam int CNT_W = $clog2(DEPTH_MAX + 1);

  logic          op_hit, free_any;
  logic          do_upd, do_alloc, do_pop, do_clear;
  logic [CW-1:0] valid_cnt;

  elb_store #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW), .CW(CW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .op_data(op_data),
    .ld_addr(ld_addr), .do_upd(do_upd), .do_alloc(do_alloc),
    .do_pop(do_pop), .do_clear(do_clear), .op_hit(op_hit),
    .free_any(free_any), .ld_hit(ld_hit), .ld_data(ld_data),
    .cm_addr(cm_addr), .cm_data(cm_data), .cm_last(cm_last),
    .valid_cnt(valid_cnt)
  );

  elb_seq #(.DEPTH_MAX(DEPTH_MAX), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .op_kind(op_kind_e'(op_kind)), .line_held(line_held),
    .conflict(conflict), .cm_ready(cm_ready), .cm_last(cm_last),
    .op_hit(op_hit), .free_any(free_any), .op_ready(op_ready),
    .do_upd(do_upd), .do_alloc(do_alloc), .do_pop(do_pop),
    .do_clear(do_clear), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .cm_valid(cm_valid)
  );

  // R9: an abort leaves nothing buffered and nothing bound for memory.
  assert_abort_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (valid_cnt == '0) && !cm_valid);
  // R7: a stalled drain word stays put.
  assert_cm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_addr) && $stable(cm_data));
  // R2: a begin always leaves at least one buffered lock.
  assert_begin_has_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_begin |-> valid_cnt != '0);
  // R10: a conflict with nothing buffered and no op is ignored.
  assert_idle_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conflict && !op_valid && !cm_valid && (valid_cnt == '0) |=> !tx_abort);
endmodule

// File: tb/sim_elided_lock_buffer.sv
module sim_elided_lock_buffer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DMAX = 6;

  typedef struct packed {
    logic          kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [2:0]    cmd;   // {abort, commit, begin}
    logic          hit;
    logic [DW-1:0] ld;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h100, 32'h11, 3'b001, 1'b1, 32'h11}, // R2
    '{1'b0, 32'h104, 32'h22, 3'b001, 1'b1, 32'h22}, // R2
    '{1'b0, 32'h100, 32'h33, 3'b001, 1'b1, 32'h33}, // R4
    '{1'b1, 32'h104, 32'h00, 3'b010, 1'b1, 32'h00}, // R6
    '{1'b1, 32'h1F0, 32'h09, 3'b100, 1'b0, 32'h00}, // R8
    '{1'b0, 32'h200, 32'hA1, 3'b001, 1'b1, 32'hA1}, // R2
    '{1'b0, 32'h204, 32'hA2, 3'b001, 1'b1, 32'hA2},
    '{1'b0, 32'h208, 32'hA3, 3'b001, 1'b1, 32'hA3},
    '{1'b0, 32'h20C, 32'hA4, 3'b001, 1'b1, 32'hA4},
    '{1'b0, 32'h210, 32'hA5, 3'b100, 1'b0, 32'h00}  // R5
  };

  logic clk = 0, rst_n = 0;
  logic line_held = 1, op_valid = 0, op_kind = 0, conflict = 0, cm_ready = 0;
  logic [AW-1:0] op_addr = '0, ld_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic op_ready, ld_hit, tx_begin, tx_commit, tx_abort, cm_valid, cm_last;
  logic [DW-1:0] ld_data, cm_data;
  logic [AW-1:0] cm_addr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  elided_lock_buffer #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(4), .DEPTH_MAX(DMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .line_held(line_held), .op_valid(op_valid),
    .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .conflict(conflict),
    .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
    .cm_data(cm_data), .cm_last(cm_last)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] cmds();
    return {tx_abort, tx_commit, tx_begin};
  endfunction

  task automatic do_op(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    op_valid = 1; op_kind = k; op_addr = a; op_data = d;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic probe(input string tag, input logic [AW-1:0] a, input logic h, input logic [DW-1:0] d);
    ld_addr = a;
    #1;
    chk({tag, " ld_hit"}, 64'(ld_hit), 64'(h));
    if (h) chk({tag, " ld_data"}, 64'(ld_data), 64'(d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL all watchdog act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmds", 64'(cmds()), 64'd0);
    chk("R1 cm_valid", 64'(cm_valid), 64'd0);
    chk("R1 op_ready", 64'(op_ready), 64'd1);
    probe("R1", 32'h0, 1'b0, '0);

    // table walk: R2 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].kind, VEC[i].addr, VEC[i].data);
      chk($sformatf("R2/R4/R5/R6/R8 vec %0d cmd", i), 64'(cmds()), 64'(VEC[i].cmd));
      chk($sformatf("R6/R8 vec %0d cm_valid", i), 64'(cm_valid), 64'd0);
      probe($sformatf("R3 vec %0d", i), VEC[i].addr, VEC[i].hit, VEC[i].ld);
    end
    probe("R5 cleared", 32'h200, 1'b0, '0);
    probe("R3 miss", 32'h7777, 1'b0, '0);

    // R12 line not held
    line_held = 0; op_valid = 1; op_kind = 0; op_addr = 32'h300; op_data = 32'h5;
    #1 chk("R12 op_ready", 64'(op_ready), 64'd0);
    @(negedge clk);
    chk("R12 cmds", 64'(cmds()), 64'd0);
    probe("R12", 32'h300, 1'b0, '0);
    op_valid = 0; line_held = 1;

    // R11 depth ceiling
    for (int i = 0; i < DMAX; i++) begin
      do_op(1'b0, 32'h400, DW'(i));
      chk("R11 begin", 64'(cmds()), 64'b001);
    end
    do_op(1'b0, 32'h400, 32'h99);
    chk("R11 abort", 64'(cmds()), 64'b100);
    probe("R11 cleared", 32'h400, 1'b0, '0);

    // R9 conflict while nested
    do_op(1'b0, 32'h500, 32'h1);
    conflict = 1;
    @(negedge clk);
    conflict = 0;
    chk("R9 abort", 64'(cmds()), 64'b100);
    chk("R9 cm_valid", 64'(cm_valid), 64'd0);
    probe("R9 cleared", 32'h500, 1'b0, '0);

    // R10 conflict while idle
    conflict = 1;
    @(negedge clk);
    conflict = 0;
    chk("R10 idle cmds", 64'(cmds()), 64'd0);

    // R7 drain with back-pressure
    do_op(1'b0, 32'h10, 32'hAA);
    do_op(1'b0, 32'h20, 32'hBB);
    do_op(1'b1, 32'h20, 32'h7);
    chk("R6 nested commit", 64'(cmds()), 64'b010);
    chk("R6 no drain", 64'(cm_valid), 64'd0);
    do_op(1'b1, 32'h10, 32'h5);
    chk("R7 final commit", 64'(cmds()), 64'b010);
    chk("R7 cm_valid", 64'(cm_valid), 64'd1);
    chk("R7 first addr", 64'(cm_addr), 64'h10);
    chk("R7 first data", 64'(cm_data), 64'h5);
    chk("R7 first last", 64'(cm_last), 64'd0);
    chk("R7 op_ready", 64'(op_ready), 64'd0);
    conflict = 1;
    @(negedge clk);
    conflict = 0;
    chk("R10 drain cmds", 64'(cmds()), 64'd0);
    chk("R10 drain held", 64'(cm_valid), 64'd1);
    chk("R7 stall addr", 64'(cm_addr), 64'h10);
    cm_ready = 1;
    @(negedge clk);
    chk("R7 second addr", 64'(cm_addr), 64'h20);
    chk("R7 second data", 64'(cm_data), 64'h7);
    chk("R7 second last", 64'(cm_last), 64'd1);
    probe("R7 popped", 32'h10, 1'b0, '0);
    @(negedge clk);
    cm_ready = 0;
    chk("R7 done", 64'(cm_valid), 64'd0);
    chk("R7 reopen", 64'(op_ready), 64'd1);
    probe("R7 empty", 32'h20, 1'b0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule